// File: doc/BRIEF.md
# Counter-Machine Processor Core

The core runs programs written for a bare counter machine. Its instruction set is small: increment a counter, decrement a counter, jump when a counter is zero, and halt. Programs sit in an internal byte-wide program store. Each instruction fills two consecutive bytes. The program counter holds an instruction index, so instruction `k` occupies bytes `2k` and `2k+1`. The core has no unconditional jump. A program gets one by testing register 0, which always reads as zero.

A host uses the core in four steps. It writes the program bytes through the load port and presets counter values through the register port while the core is not running. It then pulses `start_i`, and execution begins at instruction 0. When `halted_o` rises, the host reads the results back through the same register port. A multi-cycle fetch/fetch/execute sequence spends exactly three clock cycles on each instruction. An instruction that names a counter the core does not have stops the machine and raises `fault_o`.

Top module: `cm_core`

## Requirements
- R1: INC (byte 0 bit 7 = 0, byte 1 bits [1:0] = 00) adds one to counter `byte0[6:0]`, wrapping modulo 2^16, and advances the program counter by one.
- R2: DEC (byte 0 bit 7 = 0, byte 1 bits [1:0] = 01) subtracts one from the counter and advances the program counter by one. A counter already at zero stays at zero.
- R3: JZ (byte 0 bit 7 = 1, counter in bits [6:0]) loads the program counter with byte 1 when the counter is zero. Otherwise the program counter advances by one.
- R4: When byte 0 bit 7 is 0, byte 1 bits [1:0] of 10 or 11 mean HALT. For INC, DEC and HALT, byte 1 bits [7:2] have no effect.
- R5: HALT raises `halted_o` and leaves the counters unchanged. `pc_o` keeps the index of the halting instruction until `start_i` restarts execution at instruction 0.
- R6: Register 0 always reads as zero. Writes to it from the host or from INC/DEC are discarded, so JZ on register 0 always jumps.
- R7: INC, DEC or JZ naming a counter at index 8 or above changes no counter. It raises `fault_o` and `halted_o`, and `pc_o` holds the faulting instruction's index. The next start clears `fault_o`.
- R8: Every instruction takes exactly three cycles. After the edge that samples `start_i`, `halted_o` is seen high 3·N edges later, where N is the number of instructions executed, HALT included.
- R9: The addition program JZ 2,4; DEC 2; INC 1; JZ 0,0; HALT at instructions 0 to 4, started with counter 1 = 2 and counter 2 = 3, halts with counter 1 = 5, counter 2 = 0 and `pc_o` = 4.
- R10: Program-byte writes and counter writes from the host take effect only while the core is not running. While it runs they are discarded.
- R11: After reset `halted_o` = 0, `fault_o` = 0, `pc_o` = 0 and every counter reads zero. `reg_rdata_o` always shows the counter selected by `reg_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin execution at instruction 0 (sampled while idle or halted) |
| load_we_i | input | 1 | Program byte write enable |
| load_addr_i | input | 9 | Program byte address (instruction index × 2 + byte) |
| load_data_i | input | 8 | Program byte value |
| reg_we_i | input | 1 | Counter write enable |
| reg_addr_i | input | 3 | Counter select for write and readback |
| reg_wdata_i | input | 16 | Counter write value |
| reg_rdata_o | output | 16 | Selected counter value |
| halted_o | output | 1 | Execution stopped by HALT or fault |
| fault_o | output | 1 | Last run stopped on an out-of-range counter index |
| pc_o | output | 8 | Current instruction index |

## Verification
The addition program exercises both JZ outcomes, the register-0 jump and the counter updates together, and its cycle count tests the three-cycle rule over fourteen instructions. A one-instruction HALT program and a taken/fall-through JZ pair check the timing and the branch target on their own. Separate programs check boundary cases that the addition run never reaches: DEC at zero, INC at 0xFFFF, HALT codes carrying junk in the unused bits, writes aimed at register 0, and an index of 9 whose low bits alias counter 1. A looping program receives host writes in the middle of its run, and a later readback shows that none took effect.

// File: rtl/cm_pkg.sv
package cm_pkg;
  localparam int PC_W = 8;
  localparam int BYTE_W = 8;
  localparam int RFIELD_W = 7;

  typedef enum logic [1:0] {OP_INC, OP_DEC, OP_JZ, OP_HALT} op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH0, ST_FETCH1, ST_EXEC, ST_HALT
  } state_e;

  typedef struct packed {
    op_e                 op;
    logic [RFIELD_W-1:0] ridx;
    logic [PC_W-1:0]     target;
  } instr_t;
endpackage

// File: rtl/cm_prog_mem.sv
module cm_prog_mem
  import cm_pkg::*;
#(
  parameter int AW = PC_W + 1
) (
  input  logic              clk_i,
  input  logic              busy_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int DEPTH = 2 ** AW;

  logic [BYTE_W-1:0] mem_q [DEPTH];

  // host load blocked while running
  always_ff @(posedge clk_i) begin
    if (we_i && !busy_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cm_decode.sv
module cm_decode
  import cm_pkg::*;
#(
  parameter int NREGS = 8
) (
  input  logic [BYTE_W-1:0] b0_i,
  input  logic [BYTE_W-1:0] b1_i,
  output instr_t            instr_o,
  output logic              bad_reg_o
);
  always_comb begin
    instr_o.ridx   = b0_i[RFIELD_W-1:0];
    instr_o.target = b1_i;
    if (b0_i[BYTE_W-1]) begin
      instr_o.op = OP_JZ;
    end else begin
      unique case (b1_i[1:0])
        2'b00:   instr_o.op = OP_INC;
        2'b01:   instr_o.op = OP_DEC;
        default: instr_o.op = OP_HALT;
      endcase
    end
  end

  // HALT never names a counter
  assign bad_reg_o = (instr_o.op != OP_HALT) &&
                     (32'(instr_o.ridx) >= 32'(NREGS));
endmodule

// File: rtl/cm_regfile.sv
module cm_regfile #(
  parameter int NREGS  = 8,
  parameter int REG_W  = 16,
  parameter int RIDX_W = $clog2(NREGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              host_we_i,
  input  logic [RIDX_W-1:0] host_addr_i,
  input  logic [REG_W-1:0]  host_wdata_i,
  output logic [REG_W-1:0]  host_rdata_o,
  input  logic              ex_we_i,
  input  logic [RIDX_W-1:0] ex_addr_i,
  input  logic [REG_W-1:0]  ex_wdata_i,
  output logic [REG_W-1:0]  ex_rdata_o
);
  logic [NREGS-1:0][REG_W-1:0] regs_q;

  // entry 0 is reset and never written
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else begin
      for (int i = 1; i < NREGS; i++) begin
        if (ex_we_i && 32'(ex_addr_i) == i)
          regs_q[i] <= ex_wdata_i;
        else if (!busy_i && host_we_i && 32'(host_addr_i) == i)
          regs_q[i] <= host_wdata_i;
      end
    end
  end

  assign host_rdata_o = regs_q[host_addr_i];
  assign ex_rdata_o   = regs_q[ex_addr_i];

  // R10
  host_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && host_we_i && !ex_we_i) |=> $stable(regs_q));
endmodule

// File: rtl/cm_ctrl.sv
module cm_ctrl
  import cm_pkg::*;
#(
  parameter int NREGS  = 8,
  parameter int REG_W  = 16,
  parameter int RIDX_W = $clog2(NREGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [PC_W:0]     mem_raddr_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic [RIDX_W-1:0] rd_idx_o,
  input  logic [REG_W-1:0]  rd_val_i,
  output logic              wr_en_o,
  output logic [REG_W-1:0]  wr_val_o,
  output logic              busy_o,
  output logic              halted_o,
  output logic              fault_o,
  output logic [PC_W-1:0]   pc_o
);
  localparam logic [PC_W-1:0]  PC_ONE  = 1;
  localparam logic [REG_W-1:0] REG_ONE = 1;

  state_e            state_q;
  logic [PC_W-1:0]   pc_q;
  logic [BYTE_W-1:0] b0_q, b1_q;
  logic              fault_q;
  instr_t            dec;
  logic              bad_reg;
  logic              is_zero;
  logic              exec_ok;

  cm_decode #(.NREGS(NREGS)) u_decode (
    .b0_i      (b0_q),
    .b1_i      (b1_q),
    .instr_o   (dec),
    .bad_reg_o (bad_reg)
  );

  assign is_zero = (rd_val_i == '0);
  assign exec_ok = (state_q == ST_EXEC) && !bad_reg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      b0_q    <= '0;
      b1_q    <= '0;
      fault_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_HALT: begin
          if (start_i) begin
            state_q <= ST_FETCH0;
            pc_q    <= '0;
            fault_q <= 1'b0;
          end
        end
        ST_FETCH0: begin
          b0_q    <= mem_rdata_i;
          state_q <= ST_FETCH1;
        end
        ST_FETCH1: begin
          b1_q    <= mem_rdata_i;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          if (bad_reg) begin
            fault_q <= 1'b1;
            state_q <= ST_HALT;
          end else begin
            unique case (dec.op)
              OP_HALT: state_q <= ST_HALT;
              OP_JZ: begin
                pc_q    <= is_zero ? dec.target : pc_q + PC_ONE;
                state_q <= ST_FETCH0;
              end
              default: begin
                pc_q    <= pc_q + PC_ONE;
                state_q <= ST_FETCH0;
              end
            endcase
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_raddr_o = {pc_q, (state_q == ST_FETCH1)};
  assign rd_idx_o    = dec.ridx[RIDX_W-1:0];
  assign wr_en_o     = exec_ok && (dec.op == OP_INC || dec.op == OP_DEC);
  // DEC floors at zero
  assign wr_val_o    = (dec.op == OP_INC) ? rd_val_i + REG_ONE :
                       (is_zero ? '0 : rd_val_i - REG_ONE);
  assign busy_o      = (state_q == ST_FETCH0) || (state_q == ST_FETCH1) ||
                       (state_q == ST_EXEC);
  assign halted_o    = (state_q == ST_HALT);
  assign fault_o     = fault_q;
  assign pc_o        = pc_q;

  // R1
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_ok && dec.op == OP_INC && dec.ridx != '0) |=>
      (rd_val_i == $past(rd_val_i) + REG_ONE));
  // R2
  dec_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_ok && dec.op == OP_DEC && is_zero) |=> (rd_val_i == '0));
  // R3
  jz_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_ok && dec.op == OP_JZ && is_zero) |=> (pc_q == $past(dec.target)));
  // R3
  jz_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_ok && dec.op == OP_JZ && !is_zero) |=> (pc_q == $past(pc_q) + PC_ONE));
  // R7
  fault_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && bad_reg) |=> (halted_o && fault_o && pc_q == $past(pc_q)));
  // R5
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && !start_i) |=> (halted_o && $stable(pc_q)));
endmodule

// File: rtl/cm_core.sv
module cm_core
  import cm_pkg::*;
#(
  parameter int NREGS  = 8,
  parameter int REG_W  = 16,
  parameter int RIDX_W = $clog2(NREGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              load_we_i,
  input  logic [PC_W:0]     load_addr_i,
  input  logic [BYTE_W-1:0] load_data_i,
  input  logic              reg_we_i,
  input  logic [RIDX_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              halted_o,
  output logic              fault_o,
  output logic [PC_W-1:0]   pc_o
);
  logic              busy;
  logic [PC_W:0]     mem_raddr;
  logic [BYTE_W-1:0] mem_rdata;
  logic [RIDX_W-1:0] rd_idx;
  logic [REG_W-1:0]  rd_val;
  logic              wr_en;
  logic [REG_W-1:0]  wr_val;

  cm_prog_mem #(.AW(PC_W + 1)) u_mem (
    .clk_i   (clk_i),
    .busy_i  (busy),
    .we_i    (load_we_i),
    .waddr_i (load_addr_i),
    .wdata_i (load_data_i),
    .raddr_i (mem_raddr),
    .rdata_o (mem_rdata)
  );

  cm_regfile #(.NREGS(NREGS), .REG_W(REG_W), .RIDX_W(RIDX_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .busy_i       (busy),
    .host_we_i    (reg_we_i),
    .host_addr_i  (reg_addr_i),
    .host_wdata_i (reg_wdata_i),
    .host_rdata_o (reg_rdata_o),
    .ex_we_i      (wr_en),
    .ex_addr_i    (rd_idx),
    .ex_wdata_i   (wr_val),
    .ex_rdata_o   (rd_val)
  );

  cm_ctrl #(.NREGS(NREGS), .REG_W(REG_W), .RIDX_W(RIDX_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mem_raddr_o (mem_raddr),
    .mem_rdata_i (mem_rdata),
    .rd_idx_o    (rd_idx),
    .rd_val_i    (rd_val),
    .wr_en_o     (wr_en),
    .wr_val_o    (wr_val),
    .busy_o      (busy),
    .halted_o    (halted_o),
    .fault_o     (fault_o),
    .pc_o        (pc_o)
  );

  // R6
  reg0_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == '0) |-> (reg_rdata_o == '0));
endmodule

// File: tb/cm_core_tb.sv
module cm_core_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        load_we_i = 1'b0;
  logic [8:0]  load_addr_i = '0;
  logic [7:0]  load_data_i = '0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        halted_o, fault_o;
  logic [7:0]  pc_o;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  cm_core u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .load_we_i(load_we_i), .load_addr_i(load_addr_i), .load_data_i(load_data_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .halted_o(halted_o), .fault_o(fault_o), .pc_o(pc_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_instr(input int idx, input logic [7:0] b0, input logic [7:0] b1);
    @(negedge clk);
    load_we_i = 1'b1; load_addr_i = 9'(2 * idx); load_data_i = b0;
    @(negedge clk);
    load_addr_i = 9'(2 * idx + 1); load_data_i = b1;
    @(negedge clk);
    load_we_i = 1'b0;
  endtask

  task automatic set_reg(input int r, input logic [15:0] v);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = 3'(r); reg_wdata_i = v;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic get_reg(input int r, output int v);
    @(negedge clk);
    reg_addr_i = 3'(r);
    #1 v = int'(reg_rdata_o);
  endtask

  // pulse start, count edges after the sampling edge until halted
  task automatic run(output int n);
    @(negedge clk);
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (!halted_o && n < 2000) begin
      @(posedge clk);
      n++;
      #1;
    end
  endtask

  task automatic t_reset();
    int v;
    chk(halted_o == 1'b0, "R11 halted", int'(halted_o), 0);
    chk(fault_o == 1'b0, "R11 fault", int'(fault_o), 0);
    chk(pc_o == 8'd0, "R11 pc", int'(pc_o), 0);
    for (int r = 0; r < 8; r++) begin
      get_reg(r, v);
      chk(v == 0, "R11 counter", v, 0);
    end
  endtask

  task automatic t_halt_only();
    int n;
    put_instr(0, 8'h00, 8'h02);
    run(n);
    chk(n == 3, "R8 one-instruction cycles", n, 3);
    chk(halted_o && pc_o == 8'd0, "R5 halt pc", int'(pc_o), 0);
    put_instr(0, 8'h00, 8'h03);
    run(n);
    chk(n == 3 && pc_o == 8'd0, "R4 code 11 halts", n, 3);
  endtask

  task automatic t_add();
    int n, v;
    put_instr(0, 8'h82, 8'h04);
    put_instr(1, 8'h02, 8'h01);
    put_instr(2, 8'h01, 8'h00);
    put_instr(3, 8'h80, 8'h00);
    put_instr(4, 8'h00, 8'h02);
    set_reg(1, 16'd2);
    set_reg(2, 16'd3);
    run(n);
    chk(n == 42, "R8 addition cycles", n, 42);
    get_reg(1, v);
    chk(v == 5, "R9 sum", v, 5);
    get_reg(2, v);
    chk(v == 0, "R9 drained", v, 0);
    chk(pc_o == 8'd4, "R9 pc", int'(pc_o), 4);
  endtask

  task automatic t_dec_floor();
    int n, v;
    set_reg(3, 16'd0);
    set_reg(4, 16'd1);
    put_instr(0, 8'h03, 8'h01);
    put_instr(1, 8'h04, 8'h01);
    put_instr(2, 8'h00, 8'h02);
    run(n);
    get_reg(3, v);
    chk(v == 0, "R2 dec at zero", v, 0);
    get_reg(4, v);
    chk(v == 0, "R2 dec one", v, 0);
    chk(pc_o == 8'd2, "R2 pc advance", int'(pc_o), 2);
  endtask

  task automatic t_inc_wrap();
    int n, v;
    set_reg(5, 16'hFFFF);
    set_reg(6, 16'd7);
    put_instr(0, 8'h05, 8'h00);
    put_instr(1, 8'h06, 8'hFC);
    put_instr(2, 8'h00, 8'hFE);
    run(n);
    get_reg(5, v);
    chk(v == 0, "R1 wrap", v, 0);
    get_reg(6, v);
    chk(v == 8, "R4 inc with junk bits", v, 8);
    chk(pc_o == 8'd2 && n == 9, "R4 halt with junk bits", int'(pc_o), 2);
  endtask

  task automatic t_jz();
    int n;
    set_reg(1, 16'd0);
    set_reg(2, 16'd3);
    put_instr(0, 8'h81, 8'h05);
    put_instr(5, 8'h82, 8'h09);
    put_instr(6, 8'h00, 8'h02);
    run(n);
    chk(pc_o == 8'd6, "R3 taken then fall-through", int'(pc_o), 6);
    chk(n == 9, "R3 cycles", n, 9);
  endtask

  task automatic t_reg0();
    int n, v;
    set_reg(0, 16'h1234);
    get_reg(0, v);
    chk(v == 0, "R6 host write ignored", v, 0);
    put_instr(0, 8'h00, 8'h00);
    put_instr(1, 8'h00, 8'h01);
    put_instr(2, 8'h80, 8'h04);
    put_instr(3, 8'h00, 8'h02);
    put_instr(4, 8'h00, 8'h02);
    run(n);
    chk(pc_o == 8'd4, "R6 jz 0 always jumps", int'(pc_o), 4);
    get_reg(0, v);
    chk(v == 0, "R6 inc ignored", v, 0);
  endtask

  task automatic t_fault();
    int n, v;
    set_reg(1, 16'h0010);
    set_reg(7, 16'd0);
    put_instr(0, 8'h07, 8'h00);
    put_instr(1, 8'h09, 8'h00);
    put_instr(2, 8'h00, 8'h02);
    run(n);
    chk(halted_o && fault_o, "R7 fault raised", int'(fault_o), 1);
    chk(pc_o == 8'd1, "R7 pc holds", int'(pc_o), 1);
    get_reg(1, v);
    chk(v == 16'h0010, "R7 alias untouched", v, 16'h0010);
    get_reg(7, v);
    chk(v == 1, "R7 index 7 valid", v, 1);
    put_instr(1, 8'h8A, 8'h00);
    run(n);
    chk(fault_o && pc_o == 8'd1, "R7 jz bad index", int'(pc_o), 1);
    put_instr(1, 8'h00, 8'h02);
    run(n);
    chk(!fault_o && halted_o, "R7 restart clears fault", int'(fault_o), 0);
  endtask

  task automatic t_busy();
    int n, v;
    set_reg(1, 16'd4);
    set_reg(5, 16'd0);
    put_instr(0, 8'h81, 8'h03);
    put_instr(1, 8'h01, 8'h01);
    put_instr(2, 8'h80, 8'h00);
    put_instr(3, 8'h00, 8'h02);
    @(negedge clk);
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    reg_we_i = 1'b1; reg_addr_i = 3'd5; reg_wdata_i = 16'h0055;
    load_we_i = 1'b1; load_addr_i = 9'd7; load_data_i = 8'h00;
    @(negedge clk);
    reg_we_i = 1'b0; load_we_i = 1'b0;
    n = 0;
    while (!halted_o && n < 2000) begin
      @(posedge clk);
      n++;
      #1;
    end
    chk(pc_o == 8'd3 && halted_o, "R10 program write ignored", int'(pc_o), 3);
    get_reg(5, v);
    chk(v == 0, "R10 counter write ignored", v, 0);
    get_reg(1, v);
    chk(v == 0, "R10 loop result", v, 0);
  endtask

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_halt_only();
    t_add();
    t_dec_floor();
    t_inc_wrap();
    t_jz();
    t_reg0();
    t_fault();
    t_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule